// File: doc/BRIEF.md
# First-Match Lookup Table with Scheduled SRAM Address

This block is a small associative lookup table of 72-bit entries. A host fills it through a write port, where every entry carries its own valid bit. It then issues search commands. Each command takes two clock cycles. In the first cycle `cmd_go` is raised. In both cycles the same 72-bit key is held on `key_in`. The block compares that key against every valid entry at once, and the lowest-numbered matching entry wins.

The result leaves the block as an SRAM address with active-low chip-enable and address-latch strobes. These appear a fixed number of cycles after the command: five or six, chosen by a table-size field. The search-valid and search-found flags follow the address. They can be pushed a further zero to seven cycles later, so that they line up with slower downstream logic. A new search can start every second cycle, and results come out in the order the searches were issued.

Top module: `cam_search`

## Requirements
- R1: While `rst` is high and after it falls, `sram_ce_n` and `sram_ale_n` are 1, `sram_addr` is 0, `srch_vld` and `srch_hit` are 0, and every entry is invalid, so no search finds a match.
- R2: A cycle with `wr_en` high stores `wr_key` and the valid bit `wr_vld` at entry `wr_idx`. Any search whose second command cycle comes after that write sees the new contents.
- R3: A command is accepted in a cycle with `cmd_go` high when no command was accepted in the previous cycle. The cycle after an accepted command is its second cycle. In that cycle `cmd_go` is ignored and `key_in` is the key that gets compared.
- R4: An entry takes part in the compare only when its valid bit is set. Among all valid entries equal to the key, the one with the smallest index wins.
- R5: In the access cycle of a search that hits, `sram_addr` carries the winning index in its low bits, with zeros above. At all other times `sram_addr` is 0.
- R6: If the command is accepted in cycle c, `sram_ce_n` and `sram_ale_n` are both 0 during cycle c+5 when `tbl_size` is 2'b01, or during cycle c+6 for any other `tbl_size` value. They are 0 only in that one cycle.
- R7: `srch_vld` is 1 for exactly one cycle, `stat_dly` cycles (0 to 7) after the access cycle. `srch_hit` is 1 in that same cycle if the search found a match, and 0 at all other times.
- R8: A search that finds no match still drives both strobes low in its access cycle, with `sram_addr` at 0. It still pulses `srch_vld`, and `srch_hit` stays 0.
- R9: Commands issued every second cycle are all accepted, and each produces its own access cycle two cycles after the previous one, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_key | input | 72 | Key value to store |
| wr_vld | input | 1 | Valid bit to store with the key |
| cmd_go | input | 1 | Search command, first cycle |
| key_in | input | 72 | Search key, held for both command cycles |
| tbl_size | input | 2 | 2'b01 selects 5-cycle latency; other values select 6 |
| stat_dly | input | 3 | Extra delay of the flags behind the address, in cycles |
| sram_addr | output | 24 | SRAM address; winning index in low bits |
| sram_ce_n | output | 1 | Active-low SRAM chip enable for the access cycle |
| sram_ale_n | output | 1 | Active-low address latch enable for the access cycle |
| srch_vld | output | 1 | Search completed (delayed flag) |
| srch_hit | output | 1 | Search found a match (delayed flag) |

## Verification
A stuck or wrong valid bit shows at the ports as an unexpected miss or a wrong winning index. This appears in the access cycle of the first search that reaches that entry, five or six cycles after the command. A fault in the command phase tracking or the latency stages moves the strobe cycle, or doubles it. That is visible at the strobe pins within one search, and overlapping back-to-back searches expose it against the two-cycle spacing. A fault in the flag delay line shows as `srch_vld` pulsing in the wrong cycle, checked over every cycle of the programmed window.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam logic [1:0] TSZ_SMALL = 2'b01;
  localparam int         LAT_SMALL = 5;
  localparam int         LAT_LARGE = 6;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int DEPTH = 16,
  parameter int KEY_W = 72,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_vld,
  input  logic [KEY_W-1:0] key,
  output logic [DEPTH-1:0] match
);
  logic [KEY_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vbit;

  // Key storage: no reset, single write port.
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < DEPTH))
      mem[wr_idx] <= wr_key;
  end

  always_ff @(posedge clk) begin
    if (rst)
      vbit <= '0;
    else if (wr_en && (int'(wr_idx) < DEPTH))
      vbit[wr_idx] <= wr_vld;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vbit[g] && (mem[g] == key);
  end
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    // Scan downward so the lowest set bit is the last one written.
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = W'(i);
  end
endmodule

// File: rtl/cam_lat_pipe.sv
module cam_lat_pipe #(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 24,
  parameter int LAT_LO = 5,
  parameter int LAT_HI = 6,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic              in_hit,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic              big,
  input  logic [DLY_W-1:0]  dly,
  output logic [ADDR_W-1:0] addr,
  output logic              ce_n,
  output logic              ale_n,
  output logic              vld,
  output logic              hit
);
  localparam int NSTG  = LAT_HI - 2;
  localparam int TAP_L = LAT_LO - 3;
  localparam int TAP_H = LAT_HI - 3;
  localparam int DLY_N = 1 << DLY_W;

  logic [NSTG-1:0]  pv, ph;
  logic [IDX_W-1:0] pi [NSTG];
  logic             tap_v, tap_h;
  logic [IDX_W-1:0] tap_i;
  logic [DLY_N-1:0] fv, fh;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= '0;
      ph <= '0;
    end else begin
      pv <= {pv[NSTG-2:0], in_v};
      ph <= {ph[NSTG-2:0], in_v & in_hit};
    end
  end

  always_ff @(posedge clk) begin
    pi[0] <= in_idx;
    for (int i = 1; i < NSTG; i++) pi[i] <= pi[i-1];
  end

  assign tap_v = big ? pv[TAP_H] : pv[TAP_L];
  assign tap_h = big ? ph[TAP_H] : ph[TAP_L];
  assign tap_i = big ? pi[TAP_H] : pi[TAP_L];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      ce_n  <= 1'b1;
      ale_n <= 1'b1;
      fv    <= '0;
      fh    <= '0;
    end else begin
      addr  <= (tap_v && tap_h) ? ADDR_W'(tap_i) : '0;
      ce_n  <= ~tap_v;
      ale_n <= ~tap_v;
      fv    <= {fv[DLY_N-2:0], tap_v};
      fh    <= {fh[DLY_N-2:0], tap_v & tap_h};
    end
  end

  assign vld = fv[dly];
  assign hit = fh[dly];

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !ce_n |=> ce_n); // R6
  AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !fh[0]) |-> (addr == '0)); // R8
  AST_HIT_HAS_VLD: assert property (@(posedge clk) disable iff (rst)
    hit |-> vld); // R7
endmodule

// File: rtl/cam_search.sv
module cam_search
  import cam_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int KEY_W  = 72,
  parameter int ADDR_W = 24,
  parameter int DLY_W  = 3,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic              wr_vld,
  input  logic              cmd_go,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [1:0]        tbl_size,
  input  logic [DLY_W-1:0]  stat_dly,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ale_n,
  output logic              srch_vld,
  output logic              srch_hit
);
  logic             ph_b;
  logic             cmd_acc;
  logic [DEPTH-1:0] match;
  logic             any;
  logic [IDX_W-1:0] win;

  // Second-cycle tracker: a command occupies two cycles.
  assign cmd_acc = cmd_go & ~ph_b & ~rst;

  always_ff @(posedge clk) begin
    if (rst) ph_b <= 1'b0;
    else     ph_b <= cmd_acc;
  end

  cam_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_key (wr_key),
    .wr_vld (wr_vld),
    .key    (key_in),
    .match  (match)
  );

  cam_prio #(.N(DEPTH), .W(IDX_W)) u_prio (
    .req (match),
    .any (any),
    .idx (win)
  );

  cam_lat_pipe #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LAT_LO(LAT_SMALL),
    .LAT_HI(LAT_LARGE), .DLY_W(DLY_W)
  ) u_pipe (
    .clk    (clk),
    .rst    (rst),
    .in_v   (ph_b),
    .in_hit (any),
    .in_idx (win),
    .big    (tbl_size != TSZ_SMALL),
    .dly    (stat_dly),
    .addr   (sram_addr),
    .ce_n   (sram_ce_n),
    .ale_n  (sram_ale_n),
    .vld    (srch_vld),
    .hit    (srch_hit)
  );

  AST_CMD_CADENCE: assert property (@(posedge clk) disable iff (rst)
    ph_b |=> !ph_b); // R3
  AST_LAT_SMALL: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_acc, LAT_SMALL) && tbl_size == TSZ_SMALL) |-> !sram_ce_n); // R6
  AST_LAT_LARGE: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_acc, LAT_LARGE) && tbl_size != TSZ_SMALL) |-> !sram_ale_n); // R6
  AST_FLAG_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (stat_dly == '0) |-> (srch_vld == !sram_ce_n)); // R7
endmodule

// File: tb/cam_search_bench.sv
`timescale 1ns/1ps
module cam_search_bench;
  typedef struct packed {
    logic [71:0] key;
    logic [1:0]  tsz;
    logic [2:0]  dly;
    logic        hit;
    logic [3:0]  idx;
  } vec_t;

  localparam logic [71:0] K1 = 72'h3C_A5A5_0000_1111_2222;
  localparam logic [71:0] K2 = 72'h00_0000_0000_0000_0001;
  localparam logic [71:0] K3 = 72'hFF_FFFF_FFFF_FFFF_FFFF;
  localparam logic [71:0] K4 = 72'h12_3456_789A_BCDE_F012;
  localparam logic [71:0] K5 = 72'h80_0000_0000_0000_0000;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{K1, 2'b01, 3'd0, 1'b1, 4'd3},
    '{K2, 2'b10, 3'd0, 1'b1, 4'd0},
    '{K3, 2'b01, 3'd7, 1'b1, 4'd15},
    '{K4, 2'b01, 3'd2, 1'b0, 4'd0},
    '{K5, 2'b10, 3'd3, 1'b0, 4'd0},
    '{K1, 2'b11, 3'd5, 1'b1, 4'd3},
    '{K3, 2'b00, 3'd1, 1'b1, 4'd15}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [71:0] wr_key = '0;
  logic        wr_vld = 1'b0;
  logic        cmd_go = 1'b0;
  logic [71:0] key_in = '0;
  logic [1:0]  tbl_size = 2'b01;
  logic [2:0]  stat_dly = '0;
  logic [23:0] sram_addr;
  logic        sram_ce_n, sram_ale_n, srch_vld, srch_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cam_search u_cam_search (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
    .wr_vld(wr_vld), .cmd_go(cmd_go), .key_in(key_in), .tbl_size(tbl_size),
    .stat_dly(stat_dly), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_ale_n(sram_ale_n), .srch_vld(srch_vld), .srch_hit(srch_hit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    check(sram_ce_n && sram_ale_n && sram_addr == 0 && !srch_vld && !srch_hit,
          req, {sram_ce_n, sram_ale_n, srch_vld, srch_hit, 4'h0, sram_addr},
          {1'b1, 1'b1, 30'h0});
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [71:0] k, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_key = k; wr_vld = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Single search; samples every cycle from c+LAT-1 to c+LAT+dly+1.
  task automatic run_search(input logic [71:0] k, input logic [1:0] tsz,
                            input logic [2:0] dly, input logic ehit,
                            input logic [3:0] eidx, input string tag);
    int lat = (tsz == 2'b01) ? 5 : 6;
    logic [23:0] eaddr = ehit ? 24'(eidx) : 24'h0;
    @(negedge clk);
    cmd_go = 1'b1; key_in = k; tbl_size = tsz; stat_dly = dly;
    @(posedge clk);
    @(negedge clk);
    cmd_go = 1'b0;               // cycle B, key still held
    @(posedge clk);
    @(negedge clk);
    key_in = ~k;                 // key after B must not matter (R3)
    repeat (lat - 3) @(posedge clk);
    if (lat > 3) @(negedge clk);
    check(sram_ce_n, {tag, " R6 early strobe"}, 32'(sram_ce_n), 32'd1);
    @(posedge clk);
    @(negedge clk);
    check(!sram_ce_n && !sram_ale_n, {tag, " R6 strobes"},
          {30'h0, sram_ce_n, sram_ale_n}, 32'd0);
    check(sram_addr == eaddr, {tag, " R4 R5 R8 address"}, 32'(sram_addr), 32'(eaddr));
    for (int d = 0; d <= int'(dly); d++) begin
      if (d > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      check(srch_vld == (d == int'(dly)) && srch_hit == ((d == int'(dly)) && ehit),
            {tag, " R7 flags"}, {30'h0, srch_vld, srch_hit},
            {30'h0, 1'b1 & (d == int'(dly)), ehit & (d == int'(dly))});
    end
    @(posedge clk);
    @(negedge clk);
    check(!srch_vld && sram_ce_n, {tag, " R6 R7 single pulse"},
          {30'h0, srch_vld, sram_ce_n}, 32'd1);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (4) @(posedge clk);
    @(negedge clk);
    idle_outputs("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    idle_outputs("R1 after reset");
    run_search(K2, 2'b01, 3'd0, 1'b0, 4'd0, "R1 empty table");

    // R2: load the table
    do_write(4'd0,  K2, 1'b1);
    do_write(4'd3,  K1, 1'b1);
    do_write(4'd5,  K1, 1'b1);
    do_write(4'd7,  K4, 1'b0);
    do_write(4'd9,  K1, 1'b1);
    do_write(4'd15, K3, 1'b1);

    for (int v = 0; v < NVEC; v++)
      run_search(VEC[v].key, VEC[v].tsz, VEC[v].dly, VEC[v].hit, VEC[v].idx,
                 $sformatf("vec%0d", v));

    // R3: cmd_go held in cycle B is ignored
    @(negedge clk);
    tbl_size = 2'b01; stat_dly = 3'd0; cmd_go = 1'b1; key_in = K3;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    cmd_go = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!sram_ce_n && sram_addr == 24'd15, "R3 first result", 32'(sram_addr), 32'd15);
    @(posedge clk); @(negedge clk);
    check(sram_ce_n && !srch_vld, "R3 cycle B command ignored", 32'(sram_ce_n), 32'd1);
    repeat (4) @(posedge clk);

    // R9: back-to-back searches every second cycle
    @(negedge clk);
    cmd_go = 1'b1; key_in = K1;
    @(posedge clk); @(negedge clk);
    cmd_go = 1'b0;
    @(posedge clk); @(negedge clk);
    cmd_go = 1'b1; key_in = K3;
    @(posedge clk); @(negedge clk);
    cmd_go = 1'b0;
    @(posedge clk); @(negedge clk);
    key_in = '0;
    @(posedge clk); @(negedge clk);
    check(!sram_ce_n && sram_addr == 24'd3 && srch_hit, "R9 first in order",
          32'(sram_addr), 32'd3);
    @(posedge clk); @(negedge clk);
    check(sram_ce_n && !srch_vld, "R9 gap cycle", 32'(sram_ce_n), 32'd1);
    @(posedge clk); @(negedge clk);
    check(!sram_ce_n && sram_addr == 24'd15 && srch_hit, "R9 second in order",
          32'(sram_addr), 32'd15);
    repeat (10) @(posedge clk);

    // R2 R4: invalidate the winner, then overwrite the next one
    do_write(4'd3, K1, 1'b0);
    run_search(K1, 2'b01, 3'd0, 1'b1, 4'd5, "R2 R4 after invalidate");
    do_write(4'd5, K5, 1'b1);
    run_search(K1, 2'b10, 3'd2, 1'b1, 4'd9, "R2 R4 after overwrite");
    run_search(K5, 2'b01, 3'd4, 1'b1, 4'd5, "R2 new key");

    // R1: reset mid-run clears all valid bits
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    idle_outputs("R1 reset again");
    rst = 1'b0;
    run_search(K3, 2'b01, 3'd0, 1'b0, 4'd0, "R1 valid cleared");
    run_search(K2, 2'b10, 3'd6, 1'b0, 4'd0, "R1 R8 miss after reset");

    finish_run();
  end
endmodule